// File: doc/BRIEF.md
# Periodic Oscillator Calibration Sequencer

This block supervises an on-chip oscillator whose frequency-locked loop must not stay active during normal operation. Between calibrations the loop is held off and the clock consumers run freely. When an interval tick arrives, the sequencer first gates off every peripheral fed by the oscillator. It then runs the loop for a fixed number of reference periods so that it can lock, switches the loop off and measures the free-running oscillator over a window of reference periods.

The measurement comes from an external capture counter, which presents its count on `osc_count`. The sequencer samples that count on the reference strobe that closes the window. A count above `count_max` means the oscillator came out fast. The sequencer then reruns the lock burst and the measurement, up to a retry limit. A count at or below `count_max` ends the calibration, re-enables the peripherals and pulses `done`. When the retries are used up and the oscillator is still fast, the sequencer also finishes, but it raises a sticky `cal_error`.

Top module: `osc_cal_seq`

## Requirements
- R1: After reset `periph_en` is 1 and `fll_en`, `busy`, `done` and `cal_error` are all 0.
- R2: An `interval_tick` sampled while idle starts a calibration. From the next cycle `periph_en` is 0 and `busy` is 1. For exactly that one cycle `fll_en` stays 0.
- R3: `fll_en` rises in the cycle after the gating cycle, so it only rises while `periph_en` is 0. It then stays 1 until SETTLE_REFS reference strobes have been counted. Strobes seen in the gating cycle do not count.
- R4: The clock edge that samples the SETTLE_REFS-th strobe switches `fll_en` to 0 for the next cycle. `busy` stays 1 and `periph_en` stays 0 while the measurement window runs.
- R5: `osc_count` is sampled at the edge of the MEAS_REFS-th reference strobe after the loop was switched off. If the sample is at most `count_max`, then in the next cycle `periph_en` is 1, `busy` is 0 and `done` is 1. `done` lasts one cycle only.
- R6: If the sample is strictly greater than `count_max` and fewer than MAX_RETRY retries have been made, `fll_en` is 1 again in the next cycle. A fresh lock burst of SETTLE_REFS strobes follows, and `periph_en` stays 0.
- R7: If the sample is strictly greater than `count_max` after MAX_RETRY retries, the calibration ends as in R5 and `cal_error` becomes 1.
- R8: `cal_error` keeps its value while idle and is cleared by the next accepted `interval_tick`.
- R9: An `interval_tick` during a calibration is ignored. It neither restarts the sequence nor alters the strobe count, and after completion no new calibration starts from it.
- R10: `periph_en` is 1 exactly when `busy` is 0, and `fll_en` is never 1 while `periph_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| interval_tick | input | 1 | One-cycle request to start a calibration |
| ref_strobe | input | 1 | One-cycle pulse per reference clock period |
| osc_count | input | CNT_W | Oscillator count captured over the measurement window |
| count_max | input | CNT_W | Highest count accepted as in range |
| fll_en | output | 1 | Enables the frequency-locked loop |
| periph_en | output | 1 | Enables the oscillator's clock consumers |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle pulse when a calibration ends |
| cal_error | output | 1 | Retries exhausted with the oscillator still fast |

## Verification
The bench builds the sequencer with SETTLE_REFS=4, MEAS_REFS=3 and MAX_RETRY=2, in place of the 1024-period default lock burst. With these values a full calibration takes a few dozen cycles. That puts several scenarios in reach: the exact strobe on which the loop turns off, a measurement that fails once and then passes, and a run that uses up every retry. The count window is probed at `count_max` itself and one above it. The stray-tick case puts ticks inside both the lock burst and the measurement window.

// File: rtl/osc_cal_pkg.sv
// Shared types for the oscillator calibration sequencer.
// Assumes nothing beyond a synthesizable enum encoding.
package osc_cal_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,  // normal operation, loop off, consumers on
        ST_GATE    = 2'd1,  // consumers just gated off, loop still off
        ST_SETTLE  = 2'd2,  // loop on, counting reference periods
        ST_MEASURE = 2'd3   // loop off, measurement window open
    } cal_state_t;

endpackage

// File: rtl/ref_period_counter.sv
// Counts reference strobes while enabled and flags the strobe that
// completes a programmable number of periods.
// Assumes: limit >= 1, clr has priority and is used on every state change.
module ref_period_counter #(
    parameter int unsigned W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         ref_strobe,
    input  logic [W-1:0] limit,
    output logic         last_hit
);

    logic [W-1:0] cnt_q;

    // Period counter: cleared on request, advanced on each counted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && ref_strobe) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Terminal detect: the strobe that completes the requested count.
    always_comb begin
        last_hit = en && ref_strobe && (cnt_q == limit - 1'b1);
    end

    // The count never passes the terminal value without being cleared.
    p_cnt_below_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt_q < limit));

endmodule

// File: rtl/osc_cal_fsm.sv
// Calibration state machine: gate consumers, burst the loop, measure,
// judge and either retry or resume.
// Assumes: ticks and strobes are single-cycle pulses synchronous to clk.
module osc_cal_fsm
    import osc_cal_pkg::*;
#(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned MAX_RETRY = 3,
    localparam int unsigned RTY_W    = $clog2(MAX_RETRY + 1) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             interval_tick,
    input  logic             window_last,
    input  logic [CNT_W-1:0] osc_count,
    input  logic [CNT_W-1:0] count_max,
    output cal_state_t       state_q,
    output logic             cnt_clr,
    output logic             done_q,
    output logic             err_q
);

    cal_state_t       state_d;
    logic [RTY_W-1:0] retry_q;
    logic             too_fast;
    logic             retries_left;
    logic             finish;

    // Judgement of the captured count and of the remaining retry budget.
    always_comb begin
        too_fast     = osc_count > count_max;
        retries_left = retry_q < RTY_W'(MAX_RETRY);
        finish       = (state_q == ST_MEASURE) && window_last &&
                       !(too_fast && retries_left);
    end

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (interval_tick) state_d = ST_GATE;
            ST_GATE:    state_d = ST_SETTLE;
            ST_SETTLE:  if (window_last) state_d = ST_MEASURE;
            ST_MEASURE: if (window_last)
                            state_d = (too_fast && retries_left) ? ST_SETTLE : ST_RUN;
            default:    state_d = ST_RUN;
        endcase
        cnt_clr = (state_d != state_q);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Retry budget: reset at start, spent on each failed measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retry_q <= '0;
        end else if (state_q == ST_RUN && interval_tick) begin
            retry_q <= '0;
        end else if (state_q == ST_MEASURE && window_last && too_fast && retries_left) begin
            retry_q <= retry_q + 1'b1;
        end
    end

    // Completion pulse and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= finish;
            if (state_q == ST_RUN && interval_tick) err_q <= 1'b0;
            else if (finish && too_fast)            err_q <= 1'b1;
        end
    end

    // Retry budget is never overspent.
    p_retry_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        retry_q <= RTY_W'(MAX_RETRY));

    // A failed measurement with budget left always returns to the burst.
    p_retry_returns_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEASURE && window_last && too_fast && retries_left)
            |=> (state_q == ST_SETTLE));

endmodule

// File: rtl/osc_cal_seq.sv
// Top of the periodic oscillator calibration sequencer. Holds the loop off
// between calibrations and runs gate / burst / measure / judge on each tick.
// Assumes: osc_count is valid at the strobe closing the measurement window.
module osc_cal_seq
    import osc_cal_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SETTLE_REFS = 1024,
    parameter int unsigned MEAS_REFS   = 16,
    parameter int unsigned MAX_RETRY   = 3,
    localparam int unsigned MAX_REFS   = (SETTLE_REFS > MEAS_REFS) ? SETTLE_REFS : MEAS_REFS,
    localparam int unsigned REF_W      = $clog2(MAX_REFS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             interval_tick,
    input  logic             ref_strobe,
    input  logic [CNT_W-1:0] osc_count,
    input  logic [CNT_W-1:0] count_max,
    output logic             fll_en,
    output logic             periph_en,
    output logic             busy,
    output logic             done,
    output logic             cal_error
);

    cal_state_t       state_q;
    logic             cnt_clr;
    logic             cnt_en;
    logic             window_last;
    logic [REF_W-1:0] window_len;

    // Window selection: lock burst length or measurement length.
    always_comb begin
        cnt_en     = (state_q == ST_SETTLE) || (state_q == ST_MEASURE);
        window_len = (state_q == ST_SETTLE) ? REF_W'(SETTLE_REFS) : REF_W'(MEAS_REFS);
    end

    ref_period_counter #(.W(REF_W)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (cnt_clr),
        .en         (cnt_en),
        .ref_strobe (ref_strobe),
        .limit      (window_len),
        .last_hit   (window_last)
    );

    osc_cal_fsm #(.CNT_W(CNT_W), .MAX_RETRY(MAX_RETRY)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .interval_tick (interval_tick),
        .window_last   (window_last),
        .osc_count     (osc_count),
        .count_max     (count_max),
        .state_q       (state_q),
        .cnt_clr       (cnt_clr),
        .done_q        (done),
        .err_q         (cal_error)
    );

    // Output decode from the registered state.
    always_comb begin
        fll_en    = (state_q == ST_SETTLE);
        periph_en = (state_q == ST_RUN);
        busy      = (state_q != ST_RUN);
    end

    // The loop is never on while consumers run.
    p_no_fll_with_periph_r10: assert property (@(posedge clk) disable iff (!rst_n)
        periph_en |-> !fll_en);

    // The loop only starts after consumers were already gated.
    p_gate_before_fll_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fll_en) |-> $past(!periph_en));

    // Consumers only resume after the loop was already off.
    p_fll_off_before_resume_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(periph_en) |-> $past(!fll_en));

    // Completion is a single-cycle pulse.
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Error flag holds while idle without a new request.
    p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !interval_tick && !done) |=> $stable(cal_error));

endmodule

// File: tb/sim_osc_cal_seq.sv
module sim_osc_cal_seq;

    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          interval_tick = 1'b0;
    logic          ref_strobe = 1'b0;
    logic [CW-1:0] osc_count = '0;
    logic [CW-1:0] count_max = 12'd100;
    logic          fll_en, periph_en, busy, done, cal_error;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    osc_cal_seq #(.CNT_W(CW), .SETTLE_REFS(4), .MEAS_REFS(3), .MAX_RETRY(2)) u0 (
        .clk(clk), .rst_n(rst_n), .interval_tick(interval_tick),
        .ref_strobe(ref_strobe), .osc_count(osc_count), .count_max(count_max),
        .fll_en(fll_en), .periph_en(periph_en), .busy(busy),
        .done(done), .cal_error(cal_error)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_outs(input string req, input int f, input int p, input int b,
                            input int d, input int e);
        chk({req, " fll_en"}, fll_en, f);
        chk({req, " periph_en"}, periph_en, p);
        chk({req, " busy"}, busy, b);
        chk({req, " done"}, done, d);
        chk({req, " cal_error"}, cal_error, e);
        chk("R10 periph_en==!busy", periph_en, !busy);
    endtask

    task automatic tick();
        @(negedge clk) interval_tick = 1'b1;
        @(negedge clk) interval_tick = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk) ref_strobe = 1'b1;
        @(negedge clk) ref_strobe = 1'b0;
    endtask

    // Starts a calibration; returns with the loop on (one strobe in gate cycle).
    task automatic start_cal(input int err_before);
        @(negedge clk) interval_tick = 1'b1;
        @(negedge clk) begin interval_tick = 1'b0; ref_strobe = 1'b1; end
        chk_outs("R2 gate cycle", 0, 0, 1, 0, 0);
        @(negedge clk) ref_strobe = 1'b0;
        chk("R3 fll on after gate", fll_en, 1);
        chk("R8 error cleared by tick", cal_error, 0);
        if (err_before < 0) chk("R8 never", 0, 1);
    endtask

    task automatic settle();
        for (int i = 0; i < 3; i++) strobe();
        chk_outs("R3 burst still running", 1, 0, 1, 0, 0);
        strobe();
        chk_outs("R4 loop off for measure", 0, 0, 1, 0, 0);
    endtask

    task automatic measure(input int cnt);
        strobe();
        strobe();
        chk("R4 window open busy", busy, 1);
        osc_count = CW'(cnt);
        strobe();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_outs("R1 reset", 0, 1, 0, 0, 0);
    endtask

    task automatic t_pass_boundary();
        start_cal(0);
        settle();
        measure(100);
        chk_outs("R5 pass at count_max", 0, 1, 0, 1, 0);
        @(negedge clk);
        chk("R5 done single cycle", done, 0);
    endtask

    task automatic t_retry_once();
        start_cal(0);
        settle();
        measure(101);
        chk_outs("R6 retry on count_max+1", 1, 0, 1, 0, 0);
        settle();
        measure(50);
        chk_outs("R5 pass after retry", 0, 1, 0, 1, 0);
    endtask

    task automatic t_exhaust();
        start_cal(0);
        settle();
        measure(200);
        chk_outs("R6 first retry", 1, 0, 1, 0, 0);
        settle();
        measure(200);
        chk_outs("R6 second retry", 1, 0, 1, 0, 0);
        settle();
        measure(200);
        chk_outs("R7 retries exhausted", 0, 1, 0, 1, 1);
        repeat (5) @(negedge clk);
        chk("R8 error held while idle", cal_error, 1);
        start_cal(0);
        settle();
        measure(10);
        chk_outs("R8 clean run after error", 0, 1, 0, 1, 0);
    endtask

    task automatic t_ignore_tick();
        start_cal(0);
        strobe();
        strobe();
        tick();
        chk("R9 tick mid-burst keeps loop on", fll_en, 1);
        strobe();
        strobe();
        chk("R9 count unaffected by tick", fll_en, 0);
        strobe();
        tick();
        chk("R9 tick mid-window ignored", busy, 1);
        osc_count = 12'd20;
        strobe();
        strobe();
        chk_outs("R9 completes normally", 0, 1, 0, 1, 0);
        repeat (4) @(negedge clk);
        chk("R9 no restart after ignored tick", busy, 0);
    endtask

    initial begin
        t_reset();
        t_pass_boundary();
        t_retry_once();
        t_exhaust();
        t_ignore_tick();
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule